// File: doc/BRIEF.md
# Precision-Scalable Signed Multiplier

This block multiplies two signed two's-complement operands and returns a result as wide as one operand. A single mode input chooses between two precisions. In full precision the whole operands enter the array and the result is the upper half of the double-width product, with the lower half dropped (truncation). In reduced precision only the upper half of each operand takes part, and the result is the complete signed product of those two halves.

The array forms its partial products by the modified Baugh-Wooley method. Sign-row terms are inverted and constant correction ones are added, so one plain unsigned adder structure serves signed operands. In reduced precision, gating logic at the array inputs forces the lower operand halves to zero. The partial-product rows that belong to the lower half of the multiplier are held at zero, so the adders that sum only those rows stay still. A mode-dependent correction constant accounts for those rows. Because the gated operands are the upper halves scaled by a power of two, the reduced product appears in exactly the same output bits as the full-precision result, and no output multiplexer is needed. The result is registered once, so it appears one cycle after its inputs.

Top module: `pwrmul_top`

## Requirements
- R1: With half_mode = 0, z_out equals bits [2W-1:W] of the signed product x_in × y_in (truncation; the lower W bits are dropped).
- R2: With half_mode = 1, z_out equals the W-bit signed product of x_in[W-1:W/2] and y_in[W-1:W/2].
- R3: With half_mode = 1, the values on x_in[W/2-1:0] and y_in[W/2-1:0] have no effect on z_out.
- R4: With half_mode = 1, the partial-product rows for multiplier bits below W/2 are held at zero, so the adder group that sums them outputs zero, and the result stays correct with all-ones lower operand halves.
- R5: z_out shows the result for the inputs and mode sampled on the previous rising clock edge; a change of mode applies to the very next output with no idle cycle.
- R6: A high rst on a rising edge sets z_out to zero (synchronous, active high), and z_out stays zero while rst is held.
- R7: Extreme operands give the exact result in both modes: most-negative squared is 16'h4000 in either mode (W = 16), and most-negative times most-positive in full mode is 16'hC000.
- R8: A zero x_in gives a zero z_out in either mode.
- R9: A multiplier of one gives the other operand: in reduced mode x_in[W-1:W/2] = 1 yields y_in[W-1:W/2] sign-extended to W bits, and in full mode x_in = 1 yields W copies of the sign bit of y_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output register |
| half_mode | input | 1 | 0 = full precision, 1 = reduced precision on the upper operand halves |
| x_in | input | W | Signed multiplicand |
| y_in | input | W | Signed multiplier |
| z_out | output | W | Registered signed result |

## Verification
The bench builds the block with W = 16, the output register present and the balanced adder tree. This puts the real sign corners within reach: the most negative 16-bit and 8-bit values, the truncation boundary at bit 16, and the correction constant for the gated rows at bit positions 15 through 22. With these values a scaled reduced product lands exactly on the upper output half. Back-to-back mode changes on consecutive cycles exercise the mode-dependent correction term against a behavioural signed multiply.

// File: rtl/pwrmul_pkg.sv
`timescale 1ns/1ps
package pwrmul_pkg;

  // precision selection used throughout the datapath
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_HALF = 1'b1
  } prec_mode_e;

endpackage

// File: rtl/pwrmul_gate.sv
`timescale 1ns/1ps
// Operand isolation: zeroes the lower operand halves in reduced precision
module pwrmul_gate
  import pwrmul_pkg::*;
#(
  parameter int W = 16
) (
  input  prec_mode_e   mode,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] xg,
  output logic [W-1:0] yg
);
  localparam int LO = W / 2;

  logic keep_low;
  assign keep_low = (mode == MODE_FULL);

  assign xg = {x[W-1:LO], x[LO-1:0] & {LO{keep_low}}};
  assign yg = {y[W-1:LO], y[LO-1:0] & {LO{keep_low}}};
endmodule

// File: rtl/pwrmul_ppgen.sv
`timescale 1ns/1ps
// Modified Baugh-Wooley partial products, one row per multiplier bit
module pwrmul_ppgen
  import pwrmul_pkg::*;
#(
  parameter int W = 16
) (
  input  prec_mode_e               mode,
  input  logic [W-1:0]             a,
  input  logic [W-1:0]             b,
  output logic [W-1:0][2*W-1:0]    pp_row
);
  localparam int PW = 2 * W;
  localparam int LO = W / 2;

  for (genvar j = 0; j < W; j++) begin : g_row
    logic [W-1:0] bits;
    logic         row_en;

    for (genvar i = 0; i < W; i++) begin : g_bit
      // exactly one of the two indices on the sign position: inverted term
      if ((i == W - 1) != (j == W - 1)) begin : g_inv
        assign bits[i] = ~(a[i] & b[j]);
      end else begin : g_pos
        assign bits[i] = a[i] & b[j];
      end
    end

    // rows of the lower multiplier half feed only the full-width adders
    if (j < LO) begin : g_full_only
      assign row_en = (mode == MODE_FULL);
    end else begin : g_shared
      assign row_en = 1'b1;
    end

    assign pp_row[j] = (PW'(bits) << j) & {PW{row_en}};
  end
endmodule

// File: rtl/pwrmul_rowsum.sv
`timescale 1ns/1ps
// Sums N partial-product rows; USE_TREE picks a balanced tree or a chain
module pwrmul_rowsum #(
  parameter int PW       = 32,
  parameter int N        = 8,
  parameter bit USE_TREE = 1'b1
) (
  input  logic [N-1:0][PW-1:0] rows,
  output logic [PW-1:0]        sum
);
  if (USE_TREE) begin : g_tree
    localparam int NP = 1 << $clog2(N);
    logic [PW-1:0] node [1:2*NP-1];

    for (genvar k = 0; k < NP; k++) begin : g_leaf
      if (k < N) begin : g_used
        assign node[NP+k] = rows[k];
      end else begin : g_pad
        assign node[NP+k] = '0;
      end
    end

    for (genvar m = 1; m < NP; m++) begin : g_node
      assign node[m] = node[2*m] + node[2*m+1];
    end

    assign sum = node[1];
  end else begin : g_chain
    logic [PW-1:0] part [0:N];
    assign part[0] = '0;
    for (genvar k = 0; k < N; k++) begin : g_add
      assign part[k+1] = part[k] + rows[k];
    end
    assign sum = part[N];
  end
endmodule

// File: rtl/pwrmul_top.sv
`timescale 1ns/1ps
module pwrmul_top
  import pwrmul_pkg::*;
#(
  parameter int W        = 16,
  parameter bit REG_OUT  = 1'b1,
  parameter bit USE_TREE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         half_mode,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic [W-1:0] z_out
);
  localparam int PW = 2 * W;
  localparam int LO = W / 2;
  localparam int HI = W - LO;

  localparam logic [PW-1:0] ONE      = {{(PW-1){1'b0}}, 1'b1};
  // Baugh-Wooley correction ones at column W and column 2W-1
  localparam logic [PW-1:0] FIX_FULL = (ONE << W) | (ONE << (PW-1));
  // value the idle lower rows would carry when the multiplier low half is zero
  localparam logic [PW-1:0] FIX_LOW  = ((ONE << LO) - ONE) << (W-1);
  localparam logic [PW-1:0] FIX_HALF = FIX_FULL + FIX_LOW;

  prec_mode_e mode;
  assign mode = prec_mode_e'(half_mode);

  logic [W-1:0]          xg, yg;
  logic [W-1:0][PW-1:0]  pp_rows;
  logic [PW-1:0]         low_sum, high_sum, fix, full_sum;
  logic [W-1:0]          z_comb;
  logic                  unused_low;

  pwrmul_gate #(.W(W)) u_gate (
    .mode (mode),
    .x    (x_in),
    .y    (y_in),
    .xg   (xg),
    .yg   (yg)
  );

  pwrmul_ppgen #(.W(W)) u_pp (
    .mode   (mode),
    .a      (xg),
    .b      (yg),
    .pp_row (pp_rows)
  );

  // adders used only in full precision
  pwrmul_rowsum #(.PW(PW), .N(LO), .USE_TREE(USE_TREE)) u_low (
    .rows (pp_rows[LO-1:0]),
    .sum  (low_sum)
  );

  // adders shared by both precisions
  pwrmul_rowsum #(.PW(PW), .N(HI), .USE_TREE(USE_TREE)) u_high (
    .rows (pp_rows[W-1:LO]),
    .sum  (high_sum)
  );

  assign fix        = (mode == MODE_HALF) ? FIX_HALF : FIX_FULL;
  assign full_sum   = low_sum + high_sum + fix;
  assign z_comb     = full_sum[PW-1:W];
  assign unused_low = ^full_sum[W-1:0];

  if (REG_OUT) begin : g_reg
    logic [W-1:0] z_q;

    always_ff @(posedge clk) begin
      if (rst) z_q <= '0;
      else     z_q <= z_comb;
    end

    assign z_out = z_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> z_out == '0);  // R6

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
      x_in == '0 |=> z_out == '0);  // R8

    AST_HALF_UNIT: assert property (@(posedge clk) disable iff (rst)
      (half_mode && x_in[W-1:LO] == HI'(1)) |=>
        z_out == {{(W-HI){$past(y_in[W-1])}}, $past(y_in[W-1:LO])});  // R9

    AST_FULL_UNIT: assert property (@(posedge clk) disable iff (rst)
      (!half_mode && x_in == W'(1)) |=> z_out == {W{$past(y_in[W-1])}});  // R9
  end else begin : g_comb
    assign z_out = z_comb;
  end

  AST_LOW_ADDERS_IDLE: assert property (@(posedge clk) disable iff (rst)
    half_mode |-> low_sum == '0);  // R4
endmodule

// File: tb/pwrmul_top_test.sv
`timescale 1ns/1ps
module pwrmul_top_test;
  localparam int W = 16;

  typedef struct packed {
    logic         half;
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W-1:0] z;
  } vec_t;

  // hand-computed vectors: mode, x, y, expected z
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h4000, 16'h4000, 16'h1000},  // R1 2^28
    '{1'b0, 16'h0100, 16'h0100, 16'h0001},  // R1 2^16 boundary
    '{1'b0, 16'hFFFF, 16'h0001, 16'hFFFF},  // R1 -1 truncated
    '{1'b0, 16'h8000, 16'h8000, 16'h4000},  // R7 most negative squared
    '{1'b0, 16'h8000, 16'h7FFF, 16'hC000},  // R7 min times max
    '{1'b0, 16'h7FFF, 16'h7FFF, 16'h3FFF},  // R7 max squared
    '{1'b1, 16'h80FF, 16'h80FF, 16'h4000},  // R7 byte min squared, R4 ones low
    '{1'b1, 16'h7F00, 16'h8000, 16'hC080},  // R2 127 * -128
    '{1'b1, 16'hFF12, 16'h0334, 16'hFFFD},  // R2 -1 * 3
    '{1'b1, 16'h7FAA, 16'h7F55, 16'h3F01},  // R2 127 * 127
    '{1'b1, 16'h0000, 16'hFFFF, 16'h0000}   // R8 zero operand
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         half_mode = 1'b0;
  logic [W-1:0] x_in = '0;
  logic [W-1:0] y_in = '0;
  logic [W-1:0] z_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwrmul_top #(.W(W), .REG_OUT(1'b1), .USE_TREE(1'b1)) uut (
    .clk       (clk),
    .rst       (rst),
    .half_mode (half_mode),
    .x_in      (x_in),
    .y_in      (y_in),
    .z_out     (z_out)
  );

  function automatic logic [W-1:0] model(input logic h, input logic [W-1:0] x,
                                         input logic [W-1:0] y);
    logic signed [2*W-1:0] pf;
    logic signed [W-1:0]   ph;
    pf = $signed(x) * $signed(y);
    ph = $signed(x[W-1:W/2]) * $signed(y[W-1:W/2]);
    return h ? ph : pf[2*W-1:W];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: z_out=%h expected %h", req, act, exp);
    end
  endtask

  // drive on the falling edge, return just after the capturing rising edge
  task automatic apply(input logic h, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    half_mode = h;
    x_in      = x;
    y_in      = y;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ref_z;

    // R6: reset with busy inputs
    half_mode = 1'b0;
    x_in = 16'h7FFF;
    y_in = 16'h7FFF;
    repeat (2) @(posedge clk);
    #1;
    check("R6 reset value", z_out, 16'h0000);
    @(posedge clk);
    #1;
    check("R6 held in reset", z_out, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R7: table walk
    for (int k = 0; k < NV; k++) begin
      apply(VECS[k].half, VECS[k].x, VECS[k].y);
      check(VECS[k].half ? "R2 table half" : "R1 table full", z_out, VECS[k].z);
    end

    // R3: low halves ignored in reduced mode
    apply(1'b1, 16'h05AB, 16'hFD13);
    check("R3 low bytes set", z_out, 16'hFFF1);
    apply(1'b1, 16'h0500, 16'hFD00);
    check("R3 low bytes clear", z_out, 16'hFFF1);

    // R4: all-ones low halves, worst case for the gated rows
    apply(1'b1, 16'hC3FF, 16'h5AFF);
    check("R4 gated rows", z_out, model(1'b1, 16'hC3FF, 16'h5AFF));

    // R5: mode flips on consecutive cycles, no bubble
    apply(1'b0, 16'h8000, 16'h8001);
    check("R5 full before switch", z_out, model(1'b0, 16'h8000, 16'h8001));
    apply(1'b1, 16'h8000, 16'h8001);
    check("R5 half right after switch", z_out, 16'h4000);
    apply(1'b0, 16'h1234, 16'hF00F);
    check("R5 full right after switch", z_out, model(1'b0, 16'h1234, 16'hF00F));

    // R8: zero operand in both modes
    apply(1'b0, 16'h0000, 16'h8000);
    check("R8 zero full", z_out, 16'h0000);

    // R9: unit multiplier
    apply(1'b1, 16'h01EE, 16'h9C44);
    check("R9 unit half", z_out, 16'hFF9C);
    apply(1'b0, 16'h0001, 16'h9C44);
    check("R9 unit full", z_out, 16'hFFFF);

    // R1 R2: random operands, mixed modes
    for (int n = 0; n < 400; n++) begin
      logic         h;
      logic [W-1:0] rx, ry;
      h  = 1'($urandom);
      rx = W'($urandom);
      ry = W'($urandom);
      apply(h, rx, ry);
      ref_z = model(h, rx, ry);
      check(h ? "R2 random half" : "R1 random full", z_out, ref_z);
    end

    // R6: synchronous reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R6 reset mid-run", z_out, 16'h0000);
    @(negedge clk);
    rst = 1'b0;
    apply(1'b1, 16'h0300, 16'h0500);
    check("R6 recovery after reset", z_out, 16'h000F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule